// File: doc/BRIEF.md
# Flash Sector Decode and Write-Protect Gate

This block stands in front of the program/erase engine of a 512-Kbyte boot flash. Each clock it may take one program or erase request, made of a 19-bit byte address and a layout mode. From the address it works out the sector the request falls into and that sector's size. It then decides whether the operation may go ahead. The array can be read as eleven sectors of mixed size (the partitioned layout) or as eight equal 64-Kbyte sectors (the uniform layout). The layout is chosen per request, by the erase command that the engine is serving.

Four things can deny a request, and each acts on its own:
- two active-low hardware protect pins, one guarding the top boot sector and the other guarding every other sector;
- a bank of per-sector software lock bits, one bank for each layout;
- the reset input.

Besides the single permit flag, the block reports which of these causes denied the request. The engine acts on the permit flag and ignores the rest.

Top module: `sector_guard`

## Requirements
- R1: With `req_uniform`=0 the sector index (binary on `sec_idx`) and size in Kbytes (`sec_kb`) are: 0x00000–0x01FFF index 0 / 8, 0x02000–0x03FFF index 1 / 8, 0x04000–0x07FFF index 2 / 16, 0x08000–0x0FFFF index 3 / 32, and for addr[18:16]=n with n≥1, index n+3 / 64 (the range 0x10000–0x7FFFF covers indices 4..10).
- R2: With `req_uniform`=1 the sector index is addr[18:16] and the size is 64 Kbytes for every address.
- R3: The boot sector is addr[18:16]=7 in either layout. A valid request there is denied while `boot_lock_n` was low when the request was sampled, whatever the lock bits hold, and `deny_boot` is raised.
- R4: A valid request to any sector other than the boot sector is denied while `wprot_n` was low when the request was sampled, whatever the lock bits hold, and `deny_wp` is raised. `wprot_n` has no effect on the boot sector, and `boot_lock_n` has none on the other sectors.
- R5: With both pins high, a valid request is denied, and `deny_lock` raised, exactly when the lock bit of the addressed sector in the bank of the request's layout is 1.
- R6: When `lock_we`=1 at a clock edge, lock bit `lock_idx` of the bank picked by `lock_bank` (0 = partitioned, 11 bits; 1 = uniform, 8 bits) takes `lock_val`. An index outside the bank (≥11 or ≥8) changes nothing. Pin levels never change any lock bit.
- R7: While `rst_n` is low, `permit`=0, `deny_rst`=1 and the other deny flags are 0. Reset clears every lock bit to 0 and drops any captured request. The captured address and mode return to 0 (index 0, 8 Kbytes).
- R8: A request, its address, its mode and both pins are sampled at a rising edge when `req_valid`=1. The outputs show the verdict from that edge until the next one, and use the lock bits as updated at that same edge. With no captured request, `permit` and the three cause flags other than `deny_rst` are 0.
- R9: The two lock banks are independent. A bit set in one bank never denies a request made in the other layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; denies all writes and clears lock bits |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | 19 | Byte address of the request |
| req_uniform | input | 1 | Layout: 0 partitioned, 1 uniform |
| boot_lock_n | input | 1 | Active-low hardware protect for the boot sector |
| wprot_n | input | 1 | Active-low hardware protect for all non-boot sectors |
| lock_we | input | 1 | Lock-bit write strobe |
| lock_bank | input | 1 | Lock bank select: 0 partitioned, 1 uniform |
| lock_idx | input | 4 | Sector index of the lock bit to write |
| lock_val | input | 1 | Value written; 1 = locked |
| sec_idx | output | 4 | Sector index of the captured address |
| sec_kb | output | 7 | Sector size in Kbytes |
| permit | output | 1 | Captured request may proceed |
| deny_boot | output | 1 | Denied by the boot protect pin |
| deny_wp | output | 1 | Denied by the write-protect pin |
| deny_lock | output | 1 | Denied by a lock bit |
| deny_rst | output | 1 | Denied because reset is asserted |

## Verification
The hardest case to reach is one where the cause of a denial sits in the bank the request does not use. An example is a uniform request whose index equals a partitioned index that is locked, where the outcome must not change. Another is a lock write to an index outside the bank, whose only trace is that no sector becomes denied. The random phase keeps a model of both banks, mixes lock writes to random banks and indices (including 11–15) with requests in both layouts, and checks every cycle. Directed steps lock partitioned sector 3 and then request the same address in the uniform layout. They also write an out-of-range index and then sweep every sector to show that nothing became locked.

// File: rtl/sector_guard.sv
`timescale 1ns/1ps
module sector_guard #(
  parameter int AW    = 19,
  parameter int NPART = 11,
  parameter int NUNI  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_uniform,
  input  logic          boot_lock_n,
  input  logic          wprot_n,
  input  logic          lock_we,
  input  logic          lock_bank,
  input  logic [3:0]    lock_idx,
  input  logic          lock_val,
  output logic [3:0]    sec_idx,
  output logic [6:0]    sec_kb,
  output logic          permit,
  output logic          deny_boot,
  output logic          deny_wp,
  output logic          deny_lock,
  output logic          deny_rst
);

  logic          r_vld, r_uni, r_bl, r_wp;
  logic [AW-1:0] r_addr;
  logic [NPART-1:0] lock_part;
  logic [NUNI-1:0]  lock_uni;
  logic [15:0]      part_pad, uni_pad;
  logic [2:0]       top3;
  logic             is_boot, lock_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_vld  <= 1'b0;
      r_uni  <= 1'b0;
      r_bl   <= 1'b0;
      r_wp   <= 1'b0;
      r_addr <= '0;
    end else begin
      r_vld <= req_valid;
      if (req_valid) begin
        r_addr <= req_addr;
        r_uni  <= req_uniform;
        r_bl   <= boot_lock_n;
        r_wp   <= wprot_n;
      end
    end
  end

  for (genvar i = 0; i < NPART; i++) begin : g_part
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lock_part[i] <= 1'b0;
      else if (lock_we && !lock_bank && lock_idx == 4'(i)) lock_part[i] <= lock_val;
  end

  for (genvar i = 0; i < NUNI; i++) begin : g_uni
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lock_uni[i] <= 1'b0;
      else if (lock_we && lock_bank && lock_idx == 4'(i)) lock_uni[i] <= lock_val;
  end

  assign top3    = r_addr[AW-1:AW-3];
  assign is_boot = &top3;

  always_comb begin
    if (r_uni || top3 != 3'd0) begin
      sec_idx = r_uni ? {1'b0, top3} : {1'b0, top3} + 4'd3;
      sec_kb  = 7'd64;
    end else if (r_addr[15]) begin
      sec_idx = 4'd3; sec_kb = 7'd32;
    end else if (r_addr[14]) begin
      sec_idx = 4'd2; sec_kb = 7'd16;
    end else begin
      sec_idx = {3'd0, r_addr[13]}; sec_kb = 7'd8;
    end
  end

  assign part_pad = 16'(lock_part);
  assign uni_pad  = 16'(lock_uni);
  assign lock_hit = r_uni ? uni_pad[sec_idx] : part_pad[sec_idx];

  assign deny_rst  = ~rst_n;
  assign deny_boot = rst_n & r_vld & is_boot & ~r_bl;
  assign deny_wp   = rst_n & r_vld & ~is_boot & ~r_wp;
  assign deny_lock = rst_n & r_vld & lock_hit;
  assign permit    = rst_n & r_vld & ~deny_boot & ~deny_wp & ~deny_lock;

  // assertions
  always_comb
    if (!rst_n) assert (!permit && !deny_boot && !deny_wp && !deny_lock)
      else $error("p_reset_deny_r7");

  p_locks_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_we |=> ($stable(lock_part) && $stable(lock_uni)));

  p_boot_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !boot_lock_n && &req_addr[AW-1:AW-3]) |=> (!permit && deny_boot));

  p_wp_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wprot_n && !(&req_addr[AW-1:AW-3])) |=> (!permit && deny_wp));

  p_uniform_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_uniform) |=> (sec_idx == {1'b0, $past(req_addr[AW-1:AW-3])} && sec_kb == 7'd64));

  p_size_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sec_kb) == 1);

  p_no_req_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(permit || deny_boot || deny_wp || deny_lock));

endmodule

// File: tb/sector_guard_bench.sv
`timescale 1ns/1ps
module sector_guard_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_uniform, boot_lock_n, wprot_n, lock_we, lock_bank, lock_val;
  logic [18:0] req_addr;
  logic [3:0]  lock_idx, sec_idx;
  logic [6:0]  sec_kb;
  logic permit, deny_boot, deny_wp, deny_lock, deny_rst;

  sector_guard u_sector_guard (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit [10:0] mp;
  bit [7:0]  mu;
  bit [18:0] ma;
  bit muni, mbl, mwp, mv, mrst;

  function automatic logic [15:0] expect_vec();
    logic [3:0] idx; logic [6:0] kb; bit boot, lk, db, dw, dl, pm;
    if (muni) begin idx = {1'b0, ma[18:16]}; kb = 64; end
    else if (ma[18:16] != 0) begin idx = {1'b0, ma[18:16]} + 4'd3; kb = 64; end
    else if (ma[15]) begin idx = 3; kb = 32; end
    else if (ma[14]) begin idx = 2; kb = 16; end
    else begin idx = {3'd0, ma[13]}; kb = 8; end
    boot = (ma[18:16] == 3'd7);
    lk = muni ? mu[idx[2:0]] : mp[idx];
    db = mrst && mv && boot && !mbl;
    dw = mrst && mv && !boot && !mwp;
    dl = mrst && mv && lk;
    pm = mrst && mv && !db && !dw && !dl;
    return {idx, kb, pm, db, dw, dl, !mrst};
  endfunction

  task automatic step(input bit rst, input bit v, input logic [18:0] a, input bit uni,
                      input bit bl, input bit wp, input bit we, input bit bank,
                      input logic [3:0] idx, input bit val, input string tag);
    logic [15:0] got, exp;
    @(negedge clk);
    rst_n = rst; req_valid = v; req_addr = a; req_uniform = uni;
    boot_lock_n = bl; wprot_n = wp; lock_we = we; lock_bank = bank;
    lock_idx = idx; lock_val = val;
    mrst = rst;
    if (!rst) begin mp = 0; mu = 0; ma = 0; muni = 0; mbl = 0; mwp = 0; mv = 0; end
    else begin
      @(posedge clk);
      mv = v;
      if (v) begin ma = a; muni = uni; mbl = bl; mwp = wp; end
      if (we) begin
        if (!bank && idx < 11) mp[idx] = val;
        if (bank && idx < 8) mu[idx[2:0]] = val;
      end
    end
    #1;
    got = {sec_idx, sec_kb, permit, deny_boot, deny_wp, deny_lock, deny_rst};
    exp = expect_vec();
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h uni=%0d got=%h expected=%h", tag, ma, muni, got, exp);
    end
  endtask

  task automatic req(input logic [18:0] a, input bit uni, input bit bl, input bit wp, input string tag);
    step(1, 1, a, uni, bl, wp, 0, 0, 0, 0, tag);
  endtask

  task automatic lock(input bit bank, input logic [3:0] idx, input bit val, input string tag);
    step(1, 0, 0, 0, 1, 1, 1, bank, idx, val, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  logic [18:0] edges [12] = '{19'h00000, 19'h01FFF, 19'h02000, 19'h03FFF, 19'h04000, 19'h07FFF,
                              19'h08000, 19'h0FFFF, 19'h10000, 19'h6FFFF, 19'h70000, 19'h7FFFF};

  initial begin
    void'($urandom(32'd2024));
    step(0, 1, 19'h7FFFF, 1, 1, 1, 0, 0, 0, 0, "R7 reset state");
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R7 reset state");
    step(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R8 idle");

    foreach (edges[i]) req(edges[i], 0, 1, 1, "R1 partitioned decode");
    foreach (edges[i]) req(edges[i], 1, 1, 1, "R2 uniform decode");

    lock(0, 10, 1, "R6 lock boot bit");
    req(19'h70000, 0, 0, 1, "R3 boot pin deny");
    req(19'h7FFFF, 1, 0, 1, "R3 boot pin deny uniform");
    req(19'h6FFFF, 0, 0, 1, "R4 boot pin no effect elsewhere");
    lock(0, 10, 0, "R6 unlock");
    req(19'h00000, 0, 1, 0, "R4 wp deny");
    req(19'h7FFFF, 0, 1, 0, "R4 wp no effect on boot");

    lock(0, 3, 1, "R6 lock sector 3");
    req(19'h08000, 0, 1, 1, "R5 lock deny");
    req(19'h07FFF, 0, 1, 1, "R5 neighbour open");
    req(19'h30000, 1, 1, 1, "R9 uniform 3 unaffected");
    req(19'h08000, 1, 1, 1, "R9 other bank");
    req(19'h08000, 0, 0, 0, "R5 pins low keep lock");
    req(19'h08000, 0, 1, 1, "R6 pins do not clear lock");
    lock(1, 5, 1, "R6 uniform lock");
    req(19'h50000, 1, 1, 1, "R5 uniform lock deny");
    req(19'h20000, 0, 1, 1, "R9 part index 5 open");
    lock(0, 13, 1, "R6 out of range");
    lock(1, 9, 1, "R6 out of range");
    for (int s = 0; s < 8; s++) req({s[2:0], 16'h0}, 1, 1, 1, "R6 sweep uniform");
    foreach (edges[i]) req(edges[i], 0, 1, 1, "R6 sweep partitioned");

    step(0, 1, 19'h08000, 0, 1, 1, 0, 0, 0, 0, "R7 reset mid-run");
    req(19'h08000, 0, 1, 1, "R7 locks cleared");
    req(19'h50000, 1, 1, 1, "R7 locks cleared");

    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 64) != 0, $urandom % 4 != 0, 19'($urandom), $urandom % 2,
           $urandom % 4 != 0, $urandom % 4 != 0, $urandom % 3 == 0, $urandom % 2,
           4'($urandom), $urandom % 2, "R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule